// File: doc/BRIEF.md
# Pulsed Overload and Thermal Protection Controller

This block sits between the analog fault comparators of a supply output stage and its pass device. It takes a raw, asynchronous overload level and two temperature comparator levels (a hot trip and a cooler release), and from them produces a single output-enable line plus two status flags, one for overload and one for over-temperature.

Two overload policies are selectable at run time. In pulsed mode the controller runs a hiccup cycle: on a qualified overload it shuts the output for an off-window, re-enables it for a shorter retry window (one tenth of the off-window by default), and only returns to normal service after a retry window with no overload at all. In static mode the output is never cut for overload; the analog clamp does the limiting and the overload flag simply mirrors the qualified overload level. Thermal shutdown uses the two comparator levels as a hysteresis latch and overrides everything else. Window lengths are counted in ticks of a prescaled millisecond strobe supplied from outside.

Top module: `prot_hiccup_ctrl`

## Requirements
- R1: When `power_en` is 0, `out_enable` is 0 in every state; the flags still respond to their inputs.
- R2: `ovl_raw` passes a two-stage synchroniser and is qualified only after two consecutive equal synchronised samples; a high pulse one clock wide never sets `ovl_flag` nor drops `out_enable`.
- R3: With `static_mode` = 0 and the controller in normal service, a qualified overload drops `out_enable` and sets `ovl_flag` at the next clock edge.
- R4: The off-window lasts exactly OFF_TICKS cycles with `tick_ms` = 1 (other cycles do not count); after the last one `out_enable` returns to 1 for a retry window of ON_TICKS ticks (default OFF_TICKS/10) while `ovl_flag` stays 1.
- R5: At the last tick of the retry window, if a qualified overload was present at any cycle of the window, a new off-window begins; otherwise normal service resumes and `ovl_flag` clears.
- R6: With `static_mode` = 1, overload never drops `out_enable`, and `ovl_flag` equals the qualified overload level.
- R7: Changing `static_mode` from 1 to 0 while a qualified overload is present starts an off-window at the next clock edge; changing it from 0 to 1 abandons any hiccup cycle, restoring `out_enable` at the next edge, and `ovl_flag` follows the qualified overload at once.
- R8: `temp_flag` is set at the clock edge after `temp_trip` is 1 and cleared at the edge after `temp_release` is 1 with `temp_trip` 0; the trip wins when both are 1; otherwise it holds.
- R9: `temp_flag` = 1 forces `out_enable` to 0 whatever the hiccup state; `out_enable` is the AND of `power_en`, not `temp_flag`, and not being in an off-window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond strobe that advances the window counters |
| power_en | input | 1 | Software enable of the power output |
| static_mode | input | 1 | 1 = static clamp policy, 0 = pulsed hiccup policy |
| ovl_raw | input | 1 | Asynchronous overload comparator level |
| temp_trip | input | 1 | Over-temperature trip comparator level (hot threshold) |
| temp_release | input | 1 | Over-temperature release comparator level (cool threshold) |
| out_enable | output | 1 | Enable for the power output stage |
| ovl_flag | output | 1 | Overload status flag |
| temp_flag | output | 1 | Over-temperature status flag |

## Verification
The bound checker watches, on every cycle, the gating relations that hold in any state: the enable forcing the output off, the thermal latch forcing it off and responding to trip and release one edge later, static mode never losing the output, and pulsed mode never cutting the output without the overload flag raised. The exact window lengths, the choice between a new off-window and resumption at the end of a retry window, the rejection of narrow overload glitches and the effect of mode changes mid-cycle depend on history and counts, so only the directed scenarios of the bench show them.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        HIC_RUN   = 2'd0,
        HIC_OFF   = 2'd1,
        HIC_RETRY = 2'd2
    } hic_state_e;

    typedef struct packed {
        logic off_now;
        logic sticky;
    } hic_out_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prot_ovl_filter.sv
module prot_ovl_filter (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            level  <= 1'b0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (sync_q == prev_q) begin
                level <= sync_q;
            end
        end
    end
endmodule

// File: rtl/prot_temp_latch.sv
module prot_temp_latch (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic release_lvl,
    output logic hot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hot <= 1'b0;
        end else if (trip) begin
            hot <= 1'b1;
        end else if (release_lvl) begin
            hot <= 1'b0;
        end
    end
endmodule

// File: rtl/prot_hiccup_fsm.sv
module prot_hiccup_fsm
    import prot_pkg::*;
#(
    parameter int unsigned OFF_TICKS = 900,
    parameter int unsigned ON_TICKS  = 90
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     static_mode,
    input  logic     ovl,
    output hic_out_t status
);
    localparam int unsigned CW = cnt_width(max_u(OFF_TICKS, ON_TICKS));
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);

    hic_state_e    state;
    logic [CW-1:0] cnt;
    logic          sticky;
    logic          dirty;

    always_ff @(posedge clk) begin
        if (rst || static_mode) begin
            state  <= HIC_RUN;
            cnt    <= '0;
            sticky <= 1'b0;
            dirty  <= 1'b0;
        end else begin
            case (state)
                HIC_RUN: begin
                    if (ovl) begin
                        state  <= HIC_OFF;
                        cnt    <= '0;
                        sticky <= 1'b1;
                    end
                end
                HIC_OFF: begin
                    if (tick) begin
                        if (cnt == OFF_LAST) begin
                            state <= HIC_RETRY;
                            cnt   <= '0;
                            dirty <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                HIC_RETRY: begin
                    if (ovl) begin
                        dirty <= 1'b1;
                    end
                    if (tick) begin
                        if (cnt == ON_LAST) begin
                            cnt <= '0;
                            if (dirty || ovl) begin
                                state <= HIC_OFF;
                            end else begin
                                state  <= HIC_RUN;
                                sticky <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= HIC_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        status.off_now = (state == HIC_OFF);
        status.sticky  = sticky;
    end
endmodule

// File: rtl/prot_hiccup_ctrl.sv
module prot_hiccup_ctrl
    import prot_pkg::*;
#(
    parameter int unsigned OFF_TICKS = 900,
    parameter int unsigned ON_TICKS  = OFF_TICKS / 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_ms,
    input  logic power_en,
    input  logic static_mode,
    input  logic ovl_raw,
    input  logic temp_trip,
    input  logic temp_release,
    output logic out_enable,
    output logic ovl_flag,
    output logic temp_flag
);
    logic     ovl_q;
    hic_out_t hic;

    prot_ovl_filter u_filter (
        .clk   (clk),
        .rst   (rst),
        .raw   (ovl_raw),
        .level (ovl_q)
    );

    prot_temp_latch u_temp (
        .clk         (clk),
        .rst         (rst),
        .trip        (temp_trip),
        .release_lvl (temp_release),
        .hot         (temp_flag)
    );

    prot_hiccup_fsm #(
        .OFF_TICKS (OFF_TICKS),
        .ON_TICKS  (ON_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_ms),
        .static_mode (static_mode),
        .ovl         (ovl_q),
        .status      (hic)
    );

    assign out_enable = power_en & ~temp_flag & ~hic.off_now;
    assign ovl_flag   = static_mode ? ovl_q : hic.sticky;
endmodule

// File: rtl/prot_hiccup_ctrl_chk.sv
module prot_hiccup_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic power_en,
    input logic static_mode,
    input logic temp_trip,
    input logic temp_release,
    input logic out_enable,
    input logic ovl_flag,
    input logic temp_flag
);
    AST_EN_GATES_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !power_en |-> !out_enable); // R1

    AST_HOT_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        temp_flag |-> !out_enable); // R9

    AST_TRIP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        temp_trip |=> temp_flag); // R8

    AST_RELEASE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (temp_release && !temp_trip) |=> !temp_flag); // R8

    AST_STATIC_KEEPS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (static_mode && $past(static_mode) && power_en && !temp_flag) |-> out_enable); // R6

    AST_CUT_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!static_mode && power_en && !temp_flag && !out_enable) |-> ovl_flag); // R3
endmodule

bind prot_hiccup_ctrl prot_hiccup_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .power_en     (power_en),
    .static_mode  (static_mode),
    .temp_trip    (temp_trip),
    .temp_release (temp_release),
    .out_enable   (out_enable),
    .ovl_flag     (ovl_flag),
    .temp_flag    (temp_flag)
);

// File: tb/prot_hiccup_ctrl_tb_top.sv
`timescale 1ns/1ps
module prot_hiccup_ctrl_tb_top;
    localparam int unsigned OFF_T = 30;
    localparam int unsigned ON_T  = OFF_T / 10;

    logic clk = 1'b0;
    logic rst, tick_ms, power_en, static_mode, ovl_raw, temp_trip, temp_release;
    logic out_enable, ovl_flag, temp_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    prot_hiccup_ctrl #(.OFF_TICKS(OFF_T)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tick_ms      (tick_ms),
        .power_en     (power_en),
        .static_mode  (static_mode),
        .ovl_raw      (ovl_raw),
        .temp_trip    (temp_trip),
        .temp_release (temp_release),
        .out_enable   (out_enable),
        .ovl_flag     (ovl_flag),
        .temp_flag    (temp_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            clocks(1);
            tick_ms = 1'b0;
            clocks(1);
        end
    endtask

    task automatic overload_on;  ovl_raw = 1'b1; clocks(6); endtask
    task automatic overload_off; ovl_raw = 1'b0; clocks(6); endtask

    task automatic t_reset;
        rst = 1'b1; tick_ms = 0; power_en = 0; static_mode = 0;
        ovl_raw = 0; temp_trip = 0; temp_release = 0;
        clocks(3);
        rst = 1'b0;
        clocks(1);
        check("R1", "reset out_enable", out_enable, 1'b0);
        check("R1", "reset ovl_flag", ovl_flag, 1'b0);
        check("R1", "reset temp_flag", temp_flag, 1'b0);
        power_en = 1'b1;
        clocks(1);
        check("R9", "enabled out_enable", out_enable, 1'b1);
    endtask

    task automatic t_glitch;
        ovl_raw = 1'b1;
        clocks(1);
        ovl_raw = 1'b0;
        clocks(6);
        check("R2", "glitch out_enable", out_enable, 1'b1);
        check("R2", "glitch ovl_flag", ovl_flag, 1'b0);
    endtask

    task automatic t_hiccup;
        overload_on();
        check("R3", "trip out_enable", out_enable, 1'b0);
        check("R3", "trip ovl_flag", ovl_flag, 1'b1);
        ticks(OFF_T - 1);
        check("R4", "off window end-1", out_enable, 1'b0);
        ticks(1);
        check("R4", "retry out_enable", out_enable, 1'b1);
        check("R4", "retry ovl_flag", ovl_flag, 1'b1);
        ticks(ON_T);
        check("R5", "repeat off", out_enable, 1'b0);
        overload_off();
        ticks(OFF_T);
        check("R4", "second retry", out_enable, 1'b1);
        ticks(ON_T - 1);
        check("R5", "flag before clean end", ovl_flag, 1'b1);
        ticks(1);
        check("R5", "clean end ovl_flag", ovl_flag, 1'b0);
        check("R5", "clean end out_enable", out_enable, 1'b1);
    endtask

    task automatic t_dirty_window;
        overload_on();
        overload_off();
        ticks(OFF_T);
        check("R4", "dirty retry start", out_enable, 1'b1);
        overload_on();
        overload_off();
        ticks(ON_T);
        check("R5", "dirty window re-off", out_enable, 1'b0);
        check("R5", "dirty window flag", ovl_flag, 1'b1);
        ticks(OFF_T + ON_T);
        check("R5", "recovered flag", ovl_flag, 1'b0);
        check("R5", "recovered out", out_enable, 1'b1);
    endtask

    task automatic t_static_and_switch;
        static_mode = 1'b1;
        overload_on();
        check("R6", "static flag follows", ovl_flag, 1'b1);
        check("R6", "static out kept", out_enable, 1'b1);
        ticks(OFF_T + 5);
        check("R6", "static out after ticks", out_enable, 1'b1);
        static_mode = 1'b0;
        clocks(1);
        check("R7", "switch to pulsed off", out_enable, 1'b0);
        check("R7", "switch to pulsed flag", ovl_flag, 1'b1);
        ticks(3);
        static_mode = 1'b1;
        #1;
        check("R7", "switch to static flag now", ovl_flag, 1'b1);
        clocks(1);
        check("R7", "switch to static out", out_enable, 1'b1);
        overload_off();
        check("R6", "static flag clears", ovl_flag, 1'b0);
        static_mode = 1'b0;
        clocks(2);
        check("R7", "back to pulsed idle", out_enable, 1'b1);
    endtask

    task automatic t_thermal;
        temp_trip = 1'b1;
        clocks(1);
        temp_trip = 1'b0;
        check("R8", "trip sets flag", temp_flag, 1'b1);
        check("R9", "trip cuts out", out_enable, 1'b0);
        clocks(5);
        check("R8", "flag holds", temp_flag, 1'b1);
        temp_release = 1'b1;
        clocks(1);
        temp_release = 1'b0;
        check("R8", "release clears", temp_flag, 1'b0);
        check("R9", "release restores", out_enable, 1'b1);
        temp_trip = 1'b1; temp_release = 1'b1;
        clocks(1);
        temp_trip = 1'b0;
        check("R8", "trip wins", temp_flag, 1'b1);
        clocks(1);
        temp_release = 1'b0;
        check("R8", "release after both", temp_flag, 1'b0);
        overload_on();
        overload_off();
        ticks(OFF_T);
        check("R9", "retry before trip", out_enable, 1'b1);
        temp_trip = 1'b1;
        clocks(1);
        temp_trip = 1'b0;
        check("R9", "hot overrides retry", out_enable, 1'b0);
        temp_release = 1'b1;
        clocks(1);
        temp_release = 1'b0;
        check("R9", "retry after release", out_enable, 1'b1);
        ticks(ON_T);
        check("R5", "post-thermal clean", ovl_flag, 1'b0);
    endtask

    task automatic t_enable;
        power_en = 1'b0;
        #1;
        check("R1", "disabled out", out_enable, 1'b0);
        temp_trip = 1'b1;
        clocks(1);
        temp_trip = 1'b0;
        check("R1", "flag works while disabled", temp_flag, 1'b1);
        temp_release = 1'b1;
        clocks(1);
        temp_release = 1'b0;
        power_en = 1'b1;
        #1;
        check("R1", "re-enabled out", out_enable, 1'b1);
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_hiccup();
        t_dirty_window();
        t_static_and_switch();
        t_thermal();
        t_enable();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule